// File: doc/BRIEF.md
# I2C Byte-Step Master Controller

This block is a bus master for a two-wire serial bus. It moves one byte per host command. A host writes an address or data byte into a one-byte buffer. It then writes a control word whose go bit launches exactly one byte on the bus. Extra flags in that word ask for a (repeated) START in front of the byte, a STOP behind it, and the acknowledge value to return while receiving. A separate flag sends a bare STOP with no byte.

The controller clears the go bit itself once the byte and its acknowledge slot are done. While waiting for the next command it holds the clock line low and keeps ownership of the bus. The first byte after a START is the slave address. Its least significant bit picks the direction: 1 means the following data bytes are received, 0 means they are sent.

Both bus lines are open-drain. The block only reports when it pulls a line low, and it reads the data line back. A status register reports four things: receive-full, the acknowledge last seen from the slave, bus-busy and transmit-done. An interrupt can be raised on receive-full. The host interface is plain and has no back-pressure: the host polls the go bit and must not write the control word while go is set.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status register (offset 2) and the control register (offset 1) read 0, neither bus line is pulled low, and `irq` is low.
- R2: Control offset 1 has these bits: [0] go, [1] start, [2] stop, [3] nak, [4] abort, [5] irq enable. Setting go while the bus is free produces a START, which is SDA falling while SCL is high. It then sends the buffer byte (offset 0) MSB first. During data and acknowledge bits, SDA changes only while SCL is low.
- R3: After a byte the controller sent, status bit [1] holds the sampled acknowledge (1 = NAK) and status bit [3] (transmit-done) is set.
- R4: The go bit reads back as 0 once the byte and its acknowledge slot have finished.
- R5: After an address byte with LSB 1 is acknowledged, each go receives eight bits MSB first into the buffer and sets status bit [0] (receive-full).
- R6: On a received byte the controller pulls SDA low in the acknowledge slot when the nak bit is 0, and leaves it released when the nak bit is 1.
- R7: `irq` is high exactly while receive-full and the irq-enable bit are both set.
- R8: When stop is set with go, a STOP (SDA rising while SCL is high) follows that byte's acknowledge slot. Status bit [2] (busy) stays 1 until the STOP is finished and then returns to 0.
- R9: When start is set with go while the bus is still held, a repeated START and then the buffer byte are sent, with no STOP in between.
- R10: When abort is written with go clear while the bus is held, only a STOP is sent: no byte and no START.
- R11: Writing 1 to status bits [0], [1] or [3] clears them. Writing 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 buffer, 1 control, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Receive-full interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed level of the SDA line |

## Verification
The assertions take three things for granted. First, the host writes the control register only while go is clear. Second, `sda_in` reflects the wired-AND of the block's own pull-down and the slave's. Third, a slave changes SDA only while SCL is low. The bench meets these points directly. Its host tasks poll the go bit before every control write. Its slave model resolves the line as an open-drain AND and moves its own drive only on a falling SCL.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int AW     = 2;

  localparam logic [AW-1:0] REG_BUF  = 2'd0;
  localparam logic [AW-1:0] REG_CTRL = 2'd1;
  localparam logic [AW-1:0] REG_STAT = 2'd2;

  localparam int CB_GO = 0, CB_START = 1, CB_STOP = 2, CB_NAK = 3, CB_ABORT = 4, CB_IRQEN = 5;
  localparam int SB_RXF = 0, SB_ACK = 1, SB_BUSY = 2, SB_TXD = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_ACK, ST_STOP, ST_HOLD
  } bus_state_t;
endpackage

// File: rtl/i2cm_phase_tick.sv
module i2cm_phase_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap
      // R2: fixed-rate phases, ticks never back to back
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/i2cm_core.sv
module i2cm_core
  import i2cm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              start_sel,
  input  logic              stop_sel,
  input  logic              nak_sel,
  input  logic              abort,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              rx_done,
  output logic              tx_done,
  output logic              ack_bit,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              abort_taken,
  output logic              busy
);
  localparam int BC_W = $clog2(BYTE_W);

  bus_state_t        st;
  logic [1:0]        phase;
  logic [BC_W-1:0]   bitn;
  logic [BYTE_W-1:0] shreg;
  logic              is_addr, rw_lat, rd_mode, byte_rx, stop_lat, nak_lat, ack_smp;
  logic              tick, run;

  assign run = (st != ST_IDLE) && (st != ST_HOLD);

  i2cm_phase_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  assign done        = tick && (phase == 2'd3) && (st == ST_ACK);
  assign rx_done     = done && byte_rx;
  assign tx_done     = done && !byte_rx;
  assign ack_bit     = ack_smp;
  assign rx_byte     = shreg;
  assign abort_taken = (st == ST_HOLD) && !go && abort;
  assign busy        = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; phase <= '0; bitn <= '0; shreg <= '0;
      is_addr <= 1'b0; rw_lat <= 1'b0; rd_mode <= 1'b0; byte_rx <= 1'b0;
      stop_lat <= 1'b0; nak_lat <= 1'b0; ack_smp <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          st <= ST_START; phase <= '0; shreg <= tx_byte; rw_lat <= tx_byte[0];
          is_addr <= 1'b1; byte_rx <= 1'b0; stop_lat <= stop_sel; nak_lat <= nak_sel;
        end
        ST_HOLD: if (go) begin
          shreg <= tx_byte; phase <= '0; stop_lat <= stop_sel; nak_lat <= nak_sel;
          if (start_sel) begin
            st <= ST_START; is_addr <= 1'b1; rw_lat <= tx_byte[0]; byte_rx <= 1'b0;
          end else begin
            st <= ST_BITS; bitn <= '0; is_addr <= 1'b0; byte_rx <= rd_mode;
          end
        end else if (abort) begin
          st <= ST_STOP; phase <= '0;
        end
        default: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd2) begin
            if (st == ST_BITS && byte_rx) shreg <= {shreg[BYTE_W-2:0], sda_in};
            if (st == ST_ACK)             ack_smp <= sda_in;
          end
          if (phase == 2'd3) begin
            case (st)
              ST_START: begin st <= ST_BITS; bitn <= '0; end
              ST_BITS: begin
                if (!byte_rx) shreg <= {shreg[BYTE_W-2:0], 1'b0};
                if (bitn == BC_W'(BYTE_W - 1)) st <= ST_ACK;
                else                           bitn <= bitn + 1'b1;
              end
              ST_ACK: begin
                if (is_addr) rd_mode <= rw_lat;
                st <= stop_lat ? ST_STOP : ST_HOLD;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // Line drive per state and phase; SCL high in the middle phases of a bit
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      ST_HOLD:  scl_oe = 1'b1;
      ST_START: begin scl_oe = (phase == 2'd0) || (phase == 2'd3); sda_oe = phase[1]; end
      ST_BITS:  begin scl_oe = (phase == 2'd0) || (phase == 2'd3); sda_oe = !byte_rx && !shreg[BYTE_W-1]; end
      ST_ACK:   begin scl_oe = (phase == 2'd0) || (phase == 2'd3); sda_oe = byte_rx && !nak_lat; end
      ST_STOP:  begin scl_oe = (phase == 2'd0); sda_oe = !phase[1]; end
      default:  ;
    endcase
  end

  logic on_bits;
  assign on_bits = (st == ST_BITS) || (st == ST_ACK);

  // R2: data and acknowledge bits never move SDA while SCL is released
  assert_sda_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (on_bits && $past(on_bits) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              done,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic              ack_bit,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              abort_taken,
  input  logic              busy,
  output logic              go,
  output logic              start_sel,
  output logic              stop_sel,
  output logic              nak_sel,
  output logic              abort,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic [BYTE_W-1:0] buf_q;
  logic              irq_en, st_rxf, st_ack, st_txd;
  logic              wr_buf, wr_ctrl, wr_stat;

  assign wr_buf  = wr && (addr == REG_BUF);
  assign wr_ctrl = wr && (addr == REG_CTRL);
  assign wr_stat = wr && (addr == REG_STAT);
  assign tx_byte = buf_q;
  assign irq     = st_rxf && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0; go <= 1'b0; start_sel <= 1'b0; stop_sel <= 1'b0;
      nak_sel <= 1'b0; abort <= 1'b0; irq_en <= 1'b0;
      st_rxf <= 1'b0; st_ack <= 1'b0; st_txd <= 1'b0;
    end else begin
      if (wr_buf)  buf_q <= wdata;
      if (rx_done) buf_q <= rx_byte;

      if (wr_ctrl) begin
        go        <= wdata[CB_GO];
        start_sel <= wdata[CB_START];
        stop_sel  <= wdata[CB_STOP];
        nak_sel   <= wdata[CB_NAK];
        abort     <= wdata[CB_ABORT];
        irq_en    <= wdata[CB_IRQEN];
      end
      if (done)                  go    <= 1'b0;
      if (abort_taken || !busy)  abort <= 1'b0;

      if (wr_stat && wdata[SB_RXF]) st_rxf <= 1'b0;
      if (wr_stat && wdata[SB_ACK]) st_ack <= 1'b0;
      if (wr_stat && wdata[SB_TXD]) st_txd <= 1'b0;
      if (rx_done) st_rxf <= 1'b1;
      if (tx_done) begin st_ack <= ack_bit; st_txd <= 1'b1; end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      REG_BUF:  rdata = buf_q;
      REG_CTRL: rdata = BYTE_W'({irq_en, abort, nak_sel, stop_sel, start_sel, go});
      REG_STAT: rdata = BYTE_W'({st_txd, busy, st_ack, st_rxf});
      default:  rdata = '0;
    endcase
  end

  // R4: a finished byte always drops the go bit
  assert_go_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !go);
  // R5: receive-full only rises after a completed receive byte
  assert_rxf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_rxf) |-> $past(rx_done));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic go, start_sel, stop_sel, nak_sel, abort;
  logic done, rx_done, tx_done, ack_bit, abort_taken, busy;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .rx_done(rx_done), .tx_done(tx_done),
    .ack_bit(ack_bit), .rx_byte(rx_byte), .abort_taken(abort_taken), .busy(busy),
    .go(go), .start_sel(start_sel), .stop_sel(stop_sel), .nak_sel(nak_sel),
    .abort(abort), .tx_byte(tx_byte), .irq(irq)
  );

  i2cm_core #(.DIV(DIV)) u_core (
    .clk(clk), .rst_n(rst_n), .go(go), .start_sel(start_sel), .stop_sel(stop_sel),
    .nak_sel(nak_sel), .abort(abort), .tx_byte(tx_byte), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .rx_done(rx_done),
    .tx_done(tx_done), .ack_bit(ack_bit), .rx_byte(rx_byte),
    .abort_taken(abort_taken), .busy(busy)
  );

  // R8: a byte flagged with stop leaves the bus still busy for the STOP
  assert_busy_for_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_sel) |=> busy);
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe, sda_in;
  logic s_drive = 1'b0;

  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  wire scl_line = ~scl_oe;
  assign sda_in = ~(sda_oe | s_drive);

  i2c_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // ---------------- slave model ----------------
  int starts = 0, stops = 0, nbytes = 0, bitcnt = 0, rd_i = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic addr_ph = 1'b0, s_rd = 1'b0, s_nak = 1'b0, m_ack = 1'b0, ack_smp = 1'b0;
  logic [7:0] sh = '0, addr_seen = '0, out_b = '0;
  logic [7:0] wlog [0:7];
  logic [7:0] rd_q [0:3];

  always @(negedge clk) begin
    logic sda_l;
    sda_l = sda_in;
    if (rst_n) begin
      if (scl_line && prev_scl && prev_sda && !sda_l) begin
        starts++; bitcnt = 0; addr_ph = 1'b1; s_drive = 1'b0;
      end
      if (scl_line && prev_scl && !prev_sda && sda_l) begin
        stops++; s_drive = 1'b0;
      end
      if (scl_line && !prev_scl) begin
        if (bitcnt < 8) sh = {sh[6:0], sda_l};
        else            ack_smp = sda_l;
        bitcnt++;
      end
      if (!scl_line && prev_scl) begin
        if (bitcnt == 8) begin
          if (addr_ph) begin addr_seen = sh; s_rd = sh[0]; s_drive = !s_nak; end
          else if (!s_rd) begin wlog[nbytes % 8] = sh; nbytes++; s_drive = !s_nak; end
          else s_drive = 1'b0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (addr_ph) begin
            addr_ph = 1'b0;
            if (s_rd && !s_nak) begin out_b = rd_q[rd_i % 4]; rd_i++; s_drive = ~out_b[7]; end
            else s_drive = 1'b0;
          end else if (s_rd) begin
            m_ack = ack_smp;
            if (!ack_smp) begin out_b = rd_q[rd_i % 4]; rd_i++; s_drive = ~out_b[7]; end
            else s_drive = 1'b0;
          end else s_drive = 1'b0;
        end else if (bitcnt >= 1 && bitcnt <= 7 && s_rd && !addr_ph) begin
          s_drive = ~out_b[7 - bitcnt];
        end
      end
    end
    prev_scl = scl_line;
    prev_sda = sda_l;
  end

  // ---------------- host helpers ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_go();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd1, v);
      if (!v[0]) return;
    end
    chk(1'b0, "R4 go never cleared", 1, 0);
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd2, v);
      if (!v[2]) return;
    end
    chk(1'b0, "R8 busy never cleared", 1, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] v;
    rd(2'd2, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    chk({scl_oe, sda_oe, irq} == 3'b000, "R1 lines and irq released", {scl_oe, sda_oe, irq}, 0);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int sp;
    wr(2'd0, 8'hA0); wr(2'd1, 8'h03);
    wait_go();
    rd(2'd1, v); chk(v[0] == 1'b0, "R4 go cleared after byte", v[0], 0);
    chk(addr_seen == 8'hA0, "R2 address byte on bus", addr_seen, 8'hA0);
    chk(starts == 1, "R2 one START", starts, 1);
    rd(2'd2, v);
    chk(v[1] == 1'b0, "R3 ack recorded", v[1], 0);
    chk(v[3] == 1'b1, "R3 transmit-done set", v[3], 1);
    chk(v[2] == 1'b1, "R8 busy while bus held", v[2], 1);
    wr(2'd2, 8'h00); rd(2'd2, v);
    chk(v[3] == 1'b1, "R11 zero write keeps flag", v[3], 1);
    wr(2'd2, 8'h08); rd(2'd2, v);
    chk(v[3] == 1'b0, "R11 one write clears flag", v[3], 0);
    sp = stops;
    wr(2'd0, 8'h3C); wr(2'd1, 8'h05);
    wait_go();
    rd(2'd2, v); chk(v[2] == 1'b1, "R8 busy during STOP", v[2], 1);
    wait_idle();
    chk(wlog[0] == 8'h3C, "R2 data byte MSB first", wlog[0], 8'h3C);
    chk(stops == sp + 1, "R8 STOP after byte", stops, sp + 1);
    chk({scl_oe, sda_oe} == 2'b00, "R8 lines released after STOP", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_nak_abort();
    logic [7:0] v;
    int sp, st, nb;
    s_nak = 1'b1;
    wr(2'd0, 8'hB4); wr(2'd1, 8'h03);
    wait_go();
    rd(2'd2, v); chk(v[1] == 1'b1, "R3 NAK recorded", v[1], 1);
    sp = stops; st = starts; nb = nbytes;
    wr(2'd1, 8'h10);
    wait_idle();
    chk(stops == sp + 1, "R10 abort sends STOP", stops, sp + 1);
    chk(starts == st, "R10 abort sends no START", starts, st);
    chk(nbytes == nb, "R10 abort sends no byte", nbytes, nb);
    wr(2'd2, 8'h0B); rd(2'd2, v);
    chk(v == 8'h00, "R11 all flags cleared", v, 0);
    s_nak = 1'b0;
  endtask

  task automatic t_read_chain();
    logic [7:0] v;
    int sp, st;
    rd_q[0] = 8'h5A; rd_q[1] = 8'hC3; rd_q[2] = 8'h00; rd_q[3] = 8'h00; rd_i = 0;
    wr(2'd0, 8'hA0); wr(2'd1, 8'h03); wait_go();
    wr(2'd0, 8'h11); wr(2'd1, 8'h01); wait_go();
    chk(wlog[nbytes - 1] == 8'h11, "R2 chained data byte", wlog[nbytes - 1], 8'h11);
    sp = stops; st = starts;
    wr(2'd0, 8'hA1); wr(2'd1, 8'h03); wait_go();
    chk(starts == st + 1, "R9 repeated START", starts, st + 1);
    chk(stops == sp, "R9 no STOP between", stops, sp);
    chk(addr_seen == 8'hA1, "R9 new address sent", addr_seen, 8'hA1);
    wr(2'd2, 8'h0B);
    wr(2'd1, 8'h21); wait_go();
    rd(2'd2, v); chk(v[0] == 1'b1, "R5 receive-full set", v[0], 1);
    rd(2'd0, v); chk(v == 8'h5A, "R5 received byte", v, 8'h5A);
    chk(irq == 1'b1, "R7 irq with enable", irq, 1);
    chk(m_ack == 1'b0, "R6 ACK driven", m_ack, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); chk(v[0] == 1'b0, "R11 receive-full cleared", v[0], 0);
    chk(irq == 1'b0, "R7 irq drops with flag", irq, 0);
    wr(2'd1, 8'h0D); wait_go();
    rd(2'd2, v); chk(v[0] == 1'b1, "R5 second receive-full", v[0], 1);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    rd(2'd0, v); chk(v == 8'hC3, "R5 second received byte", v, 8'hC3);
    wait_idle();
    chk(m_ack == 1'b1, "R6 NAK on final byte", m_ack, 1);
    chk(stops == sp + 1, "R8 STOP after read", stops, sp + 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_nak_abort();
    t_read_chain();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule